// File: doc/BRIEF.md
# SMRAM address steering logic

This block is memory-side decode logic that sits between the bus masters and the memory controllers. For every valid bus access it chooses one target: the system-management RAM (SMRAM) or ordinary system RAM. The choice depends on four things together:

- the physical address;
- whether the requester is the processor or another master such as a DMA engine;
- the processor's indication that it is running in system-management mode;
- a load-mode switch that firmware sets through a one-bit configuration port.

A plain address decode is therefore not enough.

The protected window always includes a fixed 32 KB region from 0x38000 to 0x3FFFF. That region holds the handler entry point at its base and the processor state-save area at 0x3FE00–0x3FFFF. A second, larger window can be enabled by parameter, and accesses that land in it raise a flag. While management mode is active, only the processor reaches SMRAM; other masters are sent to system RAM at the same addresses. Outside management mode, the load-mode switch maps the window into the normal address space, so that the handler image can be copied in before its first use. The decision is registered, so the select strobes appear one clock after the access is presented.

Top module: `smram_steer`

## Requirements
- R1: While reset is asserted, and in the first cycles after it, both selects and the enlarged-window flag are low. The load-mode bit comes out of reset cleared.
- R2: With the default parameters, the minimum window is exactly 0x38000 through 0x3FFFF. Addresses 0x37FFF and 0x40000 always select system RAM.
- R3: With `smm_active` high, a processor access (`req_is_cpu`=1) inside the window asserts `sel_smram` on the clock after it is presented. This covers the handler entry at 0x38000 and the state-save area 0x3FE00–0x3FFFF.
- R4: With `smm_active` high, an access from another master (`req_is_cpu`=0) inside the window selects system RAM.
- R5: With `smm_active` low and the load-mode bit cleared, every valid access selects system RAM, including one inside the window.
- R6: With `smm_active` low and the load-mode bit set, a window access from any master selects SMRAM. Accesses outside the window still select system RAM.
- R7: The cycle after a valid access, exactly one of `sel_smram` and `sel_sysram` is high. The cycle after an invalid one, both are low.
- R8: The load-mode bit takes the value of `cfg_wdata` only on a clock where `cfg_we` is high, and it otherwise holds. An access presented in the same cycle as a write is still steered by the old value.
- R9: When the enlarged window is enabled, it covers addresses from EXT_BASE (default 0x100000) upward by 2^EXT_LOG2 bytes (default 0x100000 to 0x1FFFFF). Steering there follows the same rules as the minimum window, and `smram_ext` is high together with `sel_smram` for such accesses. The base bits below the window size are ignored, which forces alignment.
- R10: While `smm_active` is high, the load-mode bit has no effect on steering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe for the load-mode bit |
| cfg_wdata | input | 1 | New load-mode value |
| req_valid | input | 1 | A bus access is presented this cycle |
| req_is_cpu | input | 1 | 1 = processor, 0 = alternate master / DMA |
| req_addr | input | ADDR_W | Physical address of the access |
| smm_active | input | 1 | Processor reports system-management mode |
| sel_smram | output | 1 | Access steered to SMRAM (registered) |
| sel_sysram | output | 1 | Access steered to system RAM (registered) |
| smram_ext | output | 1 | SMRAM access lies in the enlarged window (registered) |

## Verification
The hardest case to reach from the ports is a load-mode write that coincides with an access to the window. In that cycle the access must still be steered by the old value, and the new value must apply from the next access on. The stimulus issues a write and a processor window access in the same cycle, then repeats the access on the following cycle. It also crosses the load-mode setting with management mode and with both master types, and it probes each window edge at one byte inside and one byte outside.

// File: rtl/smram_pkg.sv
package smram_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE  = 2'd0,
    ROUTE_SYS   = 2'd1,
    ROUTE_SMRAM = 2'd2
  } route_e;
endpackage

// File: rtl/smram_rst_sync.sv
module smram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/smram_win_dec.sv
module smram_win_dec #(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE      = '0,
  parameter int                SIZE_LOG2 = 15
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // Offset bits inside the window are masked off; base bits below the
  // window size therefore never matter, which forces alignment.
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] MASK = (SIZE_LOG2 >= ADDR_W) ? '0 :
                                       ~((ONE << SIZE_LOG2) - ONE);

  always_comb begin
    hit = (((addr ^ BASE) & MASK) == '0);
  end
endmodule

// File: rtl/smram_cfg.sv
module smram_cfg (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic cfg_we,
  input  logic cfg_wdata,
  output logic load_mode
);
  logic load_d;

  always_comb begin
    load_d = load_mode;
    if (cfg_we) load_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) load_mode <= 1'b0;
    else             load_mode <= load_d;
  end

  // R8: no write strobe, no change
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_we |=> $stable(load_mode));
  // R8: a write lands on the next clock
  p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_we |=> (load_mode == $past(cfg_wdata)));
endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_pkg::*;
(
  input  logic clk,
  input  logic rst_sync_n,
  input  logic req_valid,
  input  logic req_is_cpu,
  input  logic smm_active,
  input  logic load_mode,
  input  logic hit_min,
  input  logic hit_ext,
  output logic sel_smram,
  output logic sel_sysram,
  output logic smram_ext
);
  route_e route_d, route_q;
  logic   ext_d, ext_q;
  logic   in_win, granted;

  always_comb begin
    in_win  = hit_min | hit_ext;
    // Management mode: processor only; otherwise the load switch decides.
    granted = smm_active ? req_is_cpu : load_mode;
    route_d = ROUTE_NONE;
    ext_d   = 1'b0;
    if (req_valid) begin
      if (in_win && granted) begin
        route_d = ROUTE_SMRAM;
        ext_d   = hit_ext & ~hit_min;
      end else begin
        route_d = ROUTE_SYS;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      route_q <= ROUTE_NONE;
      ext_q   <= 1'b0;
    end else begin
      route_q <= route_d;
      ext_q   <= ext_d;
    end
  end

  always_comb begin
    sel_smram  = (route_q == ROUTE_SMRAM);
    sel_sysram = (route_q == ROUTE_SYS);
    smram_ext  = ext_q;
  end

  // R7: one target per valid access, none when idle
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> (sel_smram ^ sel_sysram));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!sel_smram && !sel_sysram));
  // R3: processor in management mode reaches SMRAM
  p_cpu_smm_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_is_cpu && smm_active && hit_min) |=> sel_smram);
  // R4: other masters never reach SMRAM during management mode
  p_dma_blocked_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_is_cpu && smm_active) |=> !sel_smram);
  // R5: outside management mode with load off, system RAM only
  p_plain_sys_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !smm_active && !load_mode) |=> !sel_smram);
  // R9: the enlarged-window flag only accompanies an SMRAM select
  p_ext_with_smram_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    smram_ext |-> sel_smram);
endmodule

// File: rtl/smram_steer.sv
module smram_steer #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] MIN_BASE = ADDR_W'(32'h0003_8000),
  parameter int                MIN_LOG2 = 15,
  parameter bit                EXT_EN   = 1'b1,
  parameter logic [ADDR_W-1:0] EXT_BASE = ADDR_W'(32'h0010_0000),
  parameter int                EXT_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_wdata,
  input  logic              req_valid,
  input  logic              req_is_cpu,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              smm_active,
  output logic              sel_smram,
  output logic              sel_sysram,
  output logic              smram_ext
);
  logic rst_sync_n;
  logic load_mode;
  logic hit_min, hit_ext;

  smram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  smram_cfg u_cfg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .load_mode  (load_mode)
  );

  smram_win_dec #(
    .ADDR_W    (ADDR_W),
    .BASE      (MIN_BASE),
    .SIZE_LOG2 (MIN_LOG2)
  ) u_min (
    .addr (req_addr),
    .hit  (hit_min)
  );

  generate
    if (EXT_EN) begin : g_ext
      smram_win_dec #(
        .ADDR_W    (ADDR_W),
        .BASE      (EXT_BASE),
        .SIZE_LOG2 (EXT_LOG2)
      ) u_ext (
        .addr (req_addr),
        .hit  (hit_ext)
      );
    end else begin : g_no_ext
      assign hit_ext = 1'b0;
    end
  endgenerate

  smram_route u_route (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .req_valid  (req_valid),
    .req_is_cpu (req_is_cpu),
    .smm_active (smm_active),
    .load_mode  (load_mode),
    .hit_min    (hit_min),
    .hit_ext    (hit_ext),
    .sel_smram  (sel_smram),
    .sel_sysram (sel_sysram),
    .smram_ext  (smram_ext)
  );

  // R1: nothing selected while the internal reset is held
  always_comb begin
    if (!rst_sync_n) begin
      a_reset_quiet_r1: assert (!sel_smram && !sel_sysram && !smram_ext);
    end
  end
endmodule

// File: tb/sim_smram_steer.sv
module sim_smram_steer;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  valid;
    logic  smram;
    logic  ext;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_wdata, req_valid, req_is_cpu, smm_active;
  logic [31:0] req_addr;
  logic        sel_smram, sel_sysram, smram_ext;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  logic lm     = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  smram_steer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_is_cpu(req_is_cpu), .req_addr(req_addr),
    .smm_active(smm_active), .sel_smram(sel_smram), .sel_sysram(sel_sysram),
    .smram_ext(smram_ext)
  );

  function automatic logic in_min(logic [31:0] a);
    return (a >= 32'h38000) && (a <= 32'h3FFFF);
  endfunction
  function automatic logic in_ext(logic [31:0] a);
    return (a >= 32'h100000) && (a <= 32'h1FFFFF);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // One cycle of stimulus; the expected result goes into the scoreboard.
  task automatic drive(logic v, logic cpu, logic [31:0] a, logic smm,
                       logic we, logic wd, string tag);
    exp_t e;
    logic grant;
    @(negedge clk);
    req_valid = v; req_is_cpu = cpu; req_addr = a; smm_active = smm;
    cfg_we = we; cfg_wdata = wd;
    grant   = smm ? cpu : lm;
    e.valid = v;
    e.smram = v && grant && (in_min(a) || in_ext(a));
    e.ext   = e.smram && in_ext(a) && !in_min(a);
    e.tag   = tag;
    q.push_back(e);
    if (we) lm = wd;
  endtask

  // Monitor: compare just after each rising edge.
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (sel_smram !== e.smram || sel_sysram !== (e.valid && !e.smram) ||
          smram_ext !== e.ext) begin
        fails++;
        $display("FAIL %s: got smram=%b sys=%b ext=%b expected smram=%b sys=%b ext=%b",
                 e.tag, sel_smram, sel_sysram, smram_ext,
                 e.smram, e.valid && !e.smram, e.ext);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 1'b0; req_valid = 1'b0;
    req_is_cpu = 1'b0; req_addr = '0; smm_active = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sel_smram !== 1'b0 || sel_sysram !== 1'b0 || smram_ext !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got %b%b%b expected 000", sel_smram, sel_sysram, smram_ext);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    drive(0, 1, 32'h38000, 0, 0, 0, "R1 idle after reset");
    // R1/R5: load mode cleared by reset, so window goes to system RAM
    drive(1, 1, 32'h38000, 0, 0, 0, "R1 load off at reset");
    drive(1, 0, 32'h3FFFF, 0, 0, 0, "R5 dma window no smm");
    drive(1, 1, 32'h100000, 0, 0, 0, "R5 ext window no smm");
    // R2/R3: boundaries in management mode
    drive(1, 1, 32'h37FFF, 1, 0, 0, "R2 below window");
    drive(1, 1, 32'h38000, 1, 0, 0, "R3 handler entry");
    drive(1, 1, 32'h3FE00, 1, 0, 0, "R3 save area low");
    drive(1, 1, 32'h3FFFF, 1, 0, 0, "R3 save area top");
    drive(1, 1, 32'h40000, 1, 0, 0, "R2 above window");
    drive(1, 1, 32'h0, 1, 0, 0, "R2 address zero");
    // R4: other masters during management mode
    drive(1, 0, 32'h38000, 1, 0, 0, "R4 dma entry");
    drive(1, 0, 32'h3FFF0, 1, 0, 0, "R4 dma save area");
    // R7: invalid cycles keep both selects low
    drive(0, 1, 32'h38000, 1, 0, 0, "R7 invalid in window");
    drive(1, 1, 32'h38000, 1, 0, 0, "R7 valid after invalid");
    // R8: write load mode alongside an access; old value still applies
    drive(1, 1, 32'h38000, 0, 1, 1, "R8 same-cycle write");
    drive(1, 1, 32'h38000, 0, 0, 0, "R8 write takes effect");
    // R6: load mode maps window for any master
    drive(1, 0, 32'h3C000, 0, 0, 0, "R6 dma load");
    drive(1, 1, 32'h40000, 0, 0, 0, "R6 outside window");
    drive(1, 0, 32'h37FFF, 0, 0, 0, "R6 below window");
    drive(1, 0, 32'h1FFFFF, 0, 0, 0, "R6 ext window load");
    // R10: load mode ignored in management mode
    drive(1, 0, 32'h38000, 1, 0, 0, "R10 dma with load set");
    drive(1, 1, 32'h38000, 1, 0, 0, "R10 cpu with load set");
    // R9: enlarged window
    drive(1, 1, 32'h100000, 1, 0, 0, "R9 ext base");
    drive(1, 1, 32'h1FFFFF, 1, 0, 0, "R9 ext top");
    drive(1, 1, 32'h200000, 1, 0, 0, "R9 above ext");
    drive(1, 1, 32'h0FFFFF, 1, 0, 0, "R9 below ext");
    drive(1, 0, 32'h100000, 1, 0, 0, "R9 dma ext");
    // R8: data without strobe is ignored, then a real clear
    drive(0, 1, 32'h0, 0, 0, 0, "R8 data without strobe");
    drive(1, 1, 32'h38000, 0, 0, 0, "R8 load still set");
    drive(0, 1, 32'h0, 0, 1, 0, "R8 clear write");
    drive(1, 1, 32'h38000, 0, 0, 0, "R8 load cleared");
    drive(1, 0, 32'h3FE00, 0, 0, 0, "R5 save area no smm");
    drive(0, 0, 32'h0, 0, 0, 0, "R7 final idle");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule